// File: doc/BRIEF.md
# Bitmask Dictionary Vector Decompressor

This block rebuilds a stream of 8-bit vectors from a variable-length compressed bitstream that arrives one bit per cycle. The compressor sorts each vector into one of three kinds. It can be an exact copy of one of two dictionary entries, or a dictionary entry with one aligned 2-bit slot flipped by an XOR pattern, or a raw vector that is carried verbatim. The decoder collects incoming bits in a left-aligned shift buffer. It reads the leading tag bits to learn how long the codeword is, and it decodes the codeword once every one of its bits has arrived. The rebuilt vector goes to a registered valid/ready output.

Software loads the two dictionary entries through a small write port before decoding starts. A write is accepted only while the block is idle, which means the buffer is empty and no result is pending. Backpressure from the output stops input consumption, so no bit is ever dropped.

Top module: `bmask_vec_decoder`

## Requirements
- R1: After reset `out_valid` is 0, `in_ready` is 1 and the bit buffer is empty.
- R2: The codeword `0 1 i` (3 bits) produces dictionary entry `i`, where `i`=0 selects entry 0 and `i`=1 selects entry 1.
- R3: The codeword `0 0 p[1:0] m[1:0] i` (7 bits) produces dictionary entry `i` XOR (`m` shifted left by 2*`p`). Slot `p`=0 covers bits 1:0 and slot `p`=3 covers bits 7:6.
- R4: The codeword `1 d[7:0]` (9 bits) produces `d` unchanged.
- R5: Bits are consumed most-significant first. Codewords of mixed kinds sent back to back, with no idle bits between them, each decode in order.
- R6: `out_valid` rises on the second rising edge after the edge that accepts the final bit of a codeword. The edge that accepts the bit is counted as the first.
- R7: While `out_valid` is high and `out_ready` is low, `out_data` holds steady. Once the next codeword is complete, `in_ready` drops, and no bit is lost.
- R8: A dictionary write made while the block is not idle is discarded. A write made while idle takes effect for later codewords.
- R9: The buffer never holds more than 9 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dict_we | input | 1 | Dictionary write strobe |
| dict_sel | input | 1 | Dictionary entry being written |
| dict_wdata | input | 8 | Dictionary write value |
| in_valid | input | 1 | Input bit is present |
| in_bit | input | 1 | Next compressed bit |
| in_ready | output | 1 | Decoder accepts the bit this cycle |
| out_valid | output | 1 | Rebuilt vector is present |
| out_ready | input | 1 | Consumer takes the vector |
| out_data | output | 8 | Rebuilt vector |

## Verification
Each input bit is accepted on a rising edge and is in the buffer right after that edge. The decoded vector is registered on the following edge, so a result becomes visible two edges after its final bit was accepted. The bench drives inputs on falling edges and clears them just after the accepting edge. For the latency case it samples `out_valid` on the next two falling edges and expects 0 and then 1. Stall and dictionary checks are made on the falling edge that follows the edge where the effect must appear.

// File: rtl/bmask_vec_decoder.sv
module bmask_vec_decoder #(
  parameter int VEC_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             dict_we,
  input  logic             dict_sel,
  input  logic [VEC_W-1:0] dict_wdata,
  input  logic             in_valid,
  input  logic             in_bit,
  output logic             in_ready,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [VEC_W-1:0] out_data
);
  localparam int PW       = $clog2(VEC_W / 2);
  localparam int LEN_EXA  = 3;
  localparam int LEN_MSK  = 5 + PW;
  localparam int BUF_W    = VEC_W + 1;
  localparam int CW       = $clog2(BUF_W + 1);
  localparam logic [CW-1:0] TOP = CW'(BUF_W - 1);

  logic [BUF_W-1:0] bits_q, shifted, bits_d;
  logic [CW-1:0]    cnt, cnt_mid, len, wpos;
  logic [VEC_W-1:0] dict0, dict1, entry, mask_vec, dec;
  logic             complete, take, push, idle;

  logic          tag_raw, tag_exact, idx;
  logic [PW-1:0] pos;
  logic [1:0]    pat;

  assign tag_raw   = bits_q[BUF_W-1];
  assign tag_exact = bits_q[BUF_W-2];
  assign pos       = bits_q[BUF_W-3 -: PW];
  assign pat       = bits_q[BUF_W-3-PW -: 2];
  assign idx       = tag_exact ? bits_q[BUF_W-3] : bits_q[BUF_W-5-PW];

  assign len = tag_raw ? CW'(BUF_W) : (tag_exact ? CW'(LEN_EXA) : CW'(LEN_MSK));
  assign complete = (cnt != '0) && (cnt >= len);
  assign take     = complete && (!out_valid || out_ready);
  assign in_ready = !complete || take;
  assign push     = in_valid && in_ready;
  assign idle     = (cnt == '0) && !out_valid;

  assign entry    = idx ? dict1 : dict0;
  assign mask_vec = {{(VEC_W-2){1'b0}}, pat} << {pos, 1'b0};
  assign dec      = tag_raw ? bits_q[BUF_W-2 -: VEC_W]
                  : (tag_exact ? entry : (entry ^ mask_vec));

  always_comb begin
    shifted = take ? (bits_q << len) : bits_q;
    cnt_mid = take ? (cnt - len) : cnt;
    wpos    = TOP - cnt_mid;
    bits_d  = shifted;
    if (push) bits_d[wpos] = in_bit;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bits_q    <= '0;
      cnt       <= '0;
      out_valid <= 1'b0;
      out_data  <= '0;
      dict0     <= '0;
      dict1     <= '0;
    end else begin
      bits_q <= bits_d;
      cnt    <= cnt_mid + CW'(push);
      if (take) begin
        out_valid <= 1'b1;
        out_data  <= dec;
      end else if (out_ready) begin
        out_valid <= 1'b0;
      end
      if (dict_we && idle) begin
        if (dict_sel) dict1 <= dict_wdata;
        else          dict0 <= dict_wdata;
      end
    end
  end
endmodule

// File: rtl/bmask_vec_decoder_chk.sv
module bmask_vec_decoder_chk #(
  parameter int VEC_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             dict_we,
  input logic             in_ready,
  input logic             out_valid,
  input logic             out_ready,
  input logic [VEC_W-1:0] out_data,
  input logic [VEC_W-1:0] dict0,
  input logic [VEC_W-1:0] dict1,
  input logic [$clog2(VEC_W+2)-1:0] cnt,
  input logic             idle
);
  a_r1_reset_state: assert property (@(posedge clk)
    !rst_n |=> (!out_valid && cnt == '0));

  a_r7_hold_data: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

  a_r7_drop_on_ready: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(out_valid) |-> $past(out_ready));

  a_r8_busy_write: assert property (@(posedge clk) disable iff (!rst_n)
    (dict_we && !idle) |=> ($stable(dict0) && $stable(dict1)));

  a_r9_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= ($clog2(VEC_W+2))'(VEC_W + 1));

  a_r7_ready_when_empty: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == '0) |-> in_ready);
endmodule

bind bmask_vec_decoder bmask_vec_decoder_chk #(.VEC_W(VEC_W)) u_chk (.*);

// File: tb/sim_bmask_vec_decoder.sv
module sim_bmask_vec_decoder;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       dict_we = 1'b0, dict_sel = 1'b0;
  logic [7:0] dict_wdata = '0;
  logic       in_valid = 1'b0, in_bit = 1'b0, in_ready;
  logic       out_valid, out_ready = 1'b0;
  logic [7:0] out_data;
  int checks = 0, errors = 0;

  always #5 clk = ~clk;

  bmask_vec_decoder u0 (.*);

  // {code[8:0] right-aligned, len[3:0], expected[7:0]}, dict0=A5 dict1=3C
  localparam int N = 9;
  localparam logic [20:0] TBL [N] = '{
    {9'h002, 4'd3, 8'hA5},
    {9'h002, 4'd7, 8'hA4},
    {9'h15A, 4'd9, 8'h5A},
    {9'h003, 4'd3, 8'h3C},
    {9'h01F, 4'd7, 8'hFC},
    {9'h00C, 4'd7, 8'hAD},
    {9'h1FF, 4'd9, 8'hFF},
    {9'h013, 4'd7, 8'h2C},
    {9'h100, 4'd9, 8'h00}
  };

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic send_bit(input logic b);
    @(negedge clk);
    in_valid = 1'b1;
    in_bit   = b;
    while (!in_ready) @(negedge clk);
    @(posedge clk);
    #1 in_valid = 1'b0;
  endtask

  task automatic send_code(input logic [8:0] code, input int len);
    for (int i = len - 1; i >= 0; i--) send_bit(code[i]);
  endtask

  task automatic dict_write(input logic sel, input logic [7:0] val);
    @(negedge clk);
    dict_we = 1'b1; dict_sel = sel; dict_wdata = val;
    @(posedge clk);
    #1 dict_we = 1'b0;
  endtask

  task automatic wait_out(output logic [7:0] d);
    int n = 0;
    @(negedge clk);
    while (!out_valid && n < 100) begin @(negedge clk); n++; end
    d = out_data;
  endtask

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] d;
    int got;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 out_valid", {7'b0, out_valid}, 8'h00);
    check("R1 in_ready", {7'b0, in_ready}, 8'h01);

    dict_write(1'b0, 8'hA5);
    dict_write(1'b1, 8'h3C);

    // R2 R3 R4 R5: back-to-back stream, consumer always ready
    out_ready = 1'b1;
    got = 0;
    fork
      for (int k = 0; k < N; k++) send_code(TBL[k][20:12], int'(TBL[k][11:8]));
      begin
        int guard = 0;
        while (got < N && guard < 2000) begin
          @(negedge clk);
          guard++;
          if (out_valid) begin
            case (TBL[got][11:8])
              4'd3:    check("R5/R2 exact", out_data, TBL[got][7:0]);
              4'd7:    check("R5/R3 mask", out_data, TBL[got][7:0]);
              default: check("R5/R4 raw", out_data, TBL[got][7:0]);
            endcase
            got++;
          end
        end
      end
    join
    check("R5 count", 8'(got), 8'(N));
    repeat (2) @(negedge clk);

    // R6: latency
    out_ready = 1'b0;
    send_code(9'h002, 3);
    @(negedge clk);
    check("R6 not yet valid", {7'b0, out_valid}, 8'h00);
    @(negedge clk);
    check("R6 valid", {7'b0, out_valid}, 8'h01);
    check("R6 data", out_data, 8'hA5);

    // R7: stall with second codeword complete
    send_code(9'h003, 3);
    @(negedge clk);
    check("R7 in_ready low", {7'b0, in_ready}, 8'h00);
    check("R7 data held", out_data, 8'hA5);
    out_ready = 1'b1;
    @(negedge clk);
    check("R7 next valid", {7'b0, out_valid}, 8'h01);
    check("R7 next data", out_data, 8'h3C);
    @(negedge clk);
    check("R7 drained", {7'b0, out_valid}, 8'h00);
    check("R7 ready again", {7'b0, in_ready}, 8'h01);

    // R8: write while busy dropped
    send_bit(1'b0);
    send_bit(1'b1);
    dict_write(1'b0, 8'h00);
    send_bit(1'b0);
    wait_out(d);
    check("R8 busy write ignored", d, 8'hA5);
    repeat (2) @(negedge clk);
    dict_write(1'b0, 8'h77);
    send_code(9'h002, 3);
    wait_out(d);
    check("R8 idle write applied", d, 8'h77);
    send_code(9'h00C, 7);
    wait_out(d);
    check("R8 mask on new entry", d, 8'h7F);

    repeat (3) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule